// File: doc/BRIEF.md
# Soft-Start Boost Gate Controller

This block drives the gate of the low-side switch in a boost converter. A free-running period counter sets a fixed switching frequency. Each period begins with a gate pulse whose width is a duty limit, and that limit always lies between a lower and an upper bound. After enable, or after any restart, the limit starts at the lower bound. It climbs one count at a time, paced by a short toggle-flop divider that counts period boundaries. This keeps inrush current low while the output capacitor charges.

An output-overvoltage comparator flag passes through a synchronizer and then gates the pulses. While the flag is high no pulse is emitted. A pulse that is cut short stays off until the next period boundary. Three conditions force the gate low and reset the soft-start ramp: power-on-reset not yet complete, a sleep request, and an overcurrent flag. The gate output is registered and feeds one input of a half-bridge driver. With a 25 MHz clock and the default period of 127 cycles, the switching frequency is about 196.9 kHz.

Top module: `boost_gate_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `gate` is 0 after that edge.
- R2: With the converter enabled and `cmp_hi` low, successive rising edges of `gate` are exactly PERIOD clock cycles apart.
- R3: If `por_ok` is 0, `sleep` is 1 or `ocp` is 1 at a rising edge, `gate` is 0 after that edge, for as long as the condition lasts.
- R4: The first pulse after enable has a width of exactly DUTY_MIN cycles.
- R5: With SS_STAGES = 3, the duty limit rises by one at period boundary 3 (boundaries counted from 0 at enable) and then at every 8th boundary. A raised limit applies from the next period on. Pulses 0 to 3 are therefore DUTY_MIN wide, pulse 4 is DUTY_MIN+1 wide and pulse 12 is DUTY_MIN+2 wide.
- R6: The pulse width never exceeds DUTY_MAX. Once the ramp is complete, every unchopped pulse is exactly DUTY_MAX wide.
- R7: Any shutdown (R3) returns the ramp to its start, so the first pulse after a restart is DUTY_MIN wide again.
- R8: If `cmp_hi` (1 = output above threshold) is 1 at rising edge k, `gate` is 0 after edge k+2. This is the two-flop synchronizer latency, so continuous assertion suppresses every pulse.
- R9: A pulse cut short by `cmp_hi` stays low until the next period boundary, even if `cmp_hi` falls earlier. A one-cycle `cmp_hi` one cycle into a pulse leaves exactly 3 high cycles in that period.
- R10: `gate` rises only at the first cycle of a period. After any chop, pulses resume on the original period grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| por_ok | input | 1 | 1 when power-on reset has completed |
| sleep | input | 1 | 1 requests shutdown of the converter |
| ocp | input | 1 | 1 signals overcurrent; forces shutdown |
| cmp_hi | input | 1 | Overvoltage comparator, asynchronous; 1 = output above threshold |
| gate | output | 1 | Registered gate drive for the low-side switch |

## Verification
The hardest case to reach from the ports is a chop that ends in the middle of a period: the pulse must stay low until the boundary even though the comparator has already fallen. The bench waits for a rising edge of the gate and drives the comparator high for exactly one cycle. It then counts the high cycles left in that period, relying on the fixed synchronizer latency. A reference model clocked in the bench follows every boundary and ramp step, including restarts issued in the middle of a pulse, so the full ramp and its reset after each shutdown source are compared cycle by cycle.

// File: rtl/boost_pwm_pkg.sv
// Shared helpers for the soft-start boost gate controller.
// Assumes: values handled here fit in 32 bits.
package boost_pwm_pkg;

    // Saturating increment: never exceeds hi.
    function automatic int unsigned sat_step(input int unsigned v, input int unsigned hi);
        return (v >= hi) ? hi : v + 1;
    endfunction

endpackage

// File: rtl/bpc_timebase.sv
// Period counter for the boost PWM.
// Counts 0..PERIOD-1 while running. It is parked at PERIOD-1 while halted, so the
// first running edge wraps into a full period and no short first pulse occurs.
// Assumes: PERIOD >= 2.
module bpc_timebase #(
    parameter int PERIOD = 127,
    parameter int CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic          wrap
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    // Boundary flag: last cycle of a running period.
    assign wrap = !halt && (cnt_q == LAST);

    // Next count value.
    always_comb begin
        if (halt)      cnt_d = LAST;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= LAST;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bpc_softstart.sv
// Soft-start ramp for the duty limit.
// A chain of STAGES toggle flops counts period boundaries. Each rising edge of the
// last stage raises the limit by one, saturating at DUTY_MAX. Halt clears the chain
// and returns the limit to DUTY_MIN.
// Assumes: STAGES >= 2, DUTY_MIN <= DUTY_MAX < 2**CW.
module bpc_softstart #(
    parameter int CW       = 7,
    parameter int DUTY_MIN = 13,
    parameter int DUTY_MAX = 89,
    parameter int STAGES   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic          wrap,
    output logic [CW-1:0] lim_q
);
    import boost_pwm_pkg::*;

    logic [STAGES-1:0] div_q;
    logic [STAGES-1:0] carry;
    logic              step;

    // Toggle enables: a stage flips when the boundary ripples through all lower ones.
    always_comb begin
        carry[0] = wrap;
        for (int i = 1; i < STAGES; i++) carry[i] = carry[i-1] & div_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            logic q;
            // One divide-by-two stage.
            always_ff @(posedge clk) begin
                if (!rst_n || halt) q <= 1'b0;
                else if (carry[g])  q <= ~q;
            end
            assign div_q[g] = q;
        end
    endgenerate

    // Rising edge of the slowest stage.
    assign step = carry[STAGES-1] & ~div_q[STAGES-1];

    // Duty limit register with saturating ramp.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) lim_q <= CW'(DUTY_MIN);
        else if (step)      lim_q <= CW'(sat_step(32'(lim_q), DUTY_MAX));
    end
endmodule

// File: rtl/bpc_sync.sv
// Multi-flop synchronizer for an asynchronous level.
// Assumes: STAGES >= 2.
module bpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // Shift the level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/boost_gate_ctrl.sv
// Soft-start boost gate controller (top).
// Builds the gate pulse from the period counter and a duty value that is latched at
// each boundary from the soft-start limit. The synchronized overvoltage flag chops
// pulses until the next boundary. Shutdown sources force the gate low and restart
// the ramp.
// Assumes: 1 <= DUTY_MIN <= DUTY_MAX < PERIOD; inputs other than cmp_hi are synchronous.
module boost_gate_ctrl #(
    parameter int PERIOD      = 127,
    parameter int DUTY_MIN    = 13,
    parameter int DUTY_MAX    = 89,
    parameter int SS_STAGES   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_ok,
    input  logic sleep,
    input  logic ocp,
    input  logic cmp_hi,
    output logic gate
);
    localparam int CW = $clog2(PERIOD);

    logic          halt;
    logic          wrap;
    logic          cmp_s;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim_q;
    logic [CW-1:0] duty_q, duty_d;
    logic          chop_q, chop_d;
    logic          gate_d;

    // Any shutdown source halts the converter.
    assign halt = !por_ok || sleep || ocp;

    bpc_timebase #(.PERIOD(PERIOD), .CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap(wrap)
    );

    bpc_softstart #(.CW(CW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX), .STAGES(SS_STAGES)) u_ss (
        .clk(clk), .rst_n(rst_n), .halt(halt), .wrap(wrap), .lim_q(lim_q)
    );

    bpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cmp_hi), .q(cmp_s)
    );

    // Duty value for the coming cycle: reloaded only at a boundary.
    always_comb begin
        if (halt)      duty_d = CW'(DUTY_MIN);
        else if (wrap) duty_d = lim_q;
        else           duty_d = duty_q;
    end

    // Chop state: set by the synchronized flag, cleared only at a boundary.
    assign chop_d = !halt && (cmp_s || (chop_q && !wrap));

    // Gate for the coming cycle.
    assign gate_d = !halt && (cnt_d < duty_d) && !chop_d;

    // Duty, chop and gate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= CW'(DUTY_MIN);
            chop_q <= 1'b0;
            gate   <= 1'b0;
        end else begin
            duty_q <= duty_d;
            chop_q <= chop_d;
            gate   <= gate_d;
        end
    end
endmodule

// File: rtl/boost_gate_chk.sv
// Property checker for boost_gate_ctrl, attached by bind below.
// Assumes: observes the top's ports and internal state without driving anything.
module boost_gate_chk #(
    parameter int CW       = 7,
    parameter int DUTY_MIN = 13,
    parameter int DUTY_MAX = 89
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt,
    input logic          wrap,
    input logic          cmp_s,
    input logic          gate,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] lim,
    input logic [CW-1:0] duty
);
    // R3
    shutdown_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !gate);

    // R8
    chop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_s |=> !gate);

    // R6
    lim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim >= CW'(DUTY_MIN)) && (lim <= CW'(DUTY_MAX)));

    // R5
    lim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim == $past(lim)) || (lim == $past(lim) + CW'(1)) || (lim == CW'(DUTY_MIN)));

    // R10
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (cnt == '0));

    // R5
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !halt) |=> $stable(duty));
endmodule

bind boost_gate_ctrl boost_gate_chk #(
    .CW(CW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .halt(halt), .wrap(wrap), .cmp_s(cmp_s),
    .gate(gate), .cnt(cnt_q), .lim(lim_q), .duty(duty_q)
);

// File: tb/boost_gate_ctrl_tb_top.sv
// Bench for boost_gate_ctrl: a behavioural model compared on every clock, plus
// targeted pulse-width, period and chop measurements.
module boost_gate_ctrl_tb_top;
    localparam int P    = 20;
    localparam int DMIN = 4;
    localparam int DMAX = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_ok = 1'b0, sleep = 1'b0, ocp = 1'b0, cmp_hi = 1'b0;
    logic gate;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;
    int    cyc = 0;

    always #5 clk = ~clk;

    boost_gate_ctrl #(.PERIOD(P), .DUTY_MIN(DMIN), .DUTY_MAX(DMAX), .SS_STAGES(3), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .sleep(sleep), .ocp(ocp),
        .cmp_hi(cmp_hi), .gate(gate)
    );

    // Behavioural reference model.
    int m_pos = P - 1, m_lim = DMIN, m_duty = DMIN, m_bounds = 0;
    bit m_chop = 1'b0, m_gate = 1'b0;
    bit sq[$] = '{1'b0, 1'b0};

    always @(posedge clk) begin
        bit seen, off, edge_b;
        cyc++;
        if (!rst_n) begin
            m_pos = P - 1; m_lim = DMIN; m_duty = DMIN; m_bounds = 0;
            m_chop = 0; m_gate = 0; sq = '{1'b0, 1'b0};
        end else begin
            seen = sq[0];
            void'(sq.pop_front());
            sq.push_back(cmp_hi);
            off = !por_ok || sleep || ocp;
            if (off) begin
                m_pos = P - 1; m_lim = DMIN; m_duty = DMIN; m_bounds = 0;
                m_chop = 0; m_gate = 0;
            end else begin
                edge_b = (m_pos == P - 1);
                if (edge_b) begin
                    m_duty = m_lim;
                    if ((m_bounds % 8) == 3 && m_lim < DMAX) m_lim++;
                    m_bounds++;
                    m_pos = 0;
                end else m_pos++;
                m_chop = seen || (m_chop && !edge_b);
                m_gate = (m_pos < m_duty) && !m_chop;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en) chk(cur_req, int'(gate), int'(m_gate));
    end

    task automatic wait_rise(input string req);
        bit p = gate;
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk);
            if (gate && !p) return;
            p = gate;
        end
        chk(req, 0, 1);
    endtask

    task automatic pulse_width(input string req, output int w);
        wait_rise(req);
        w = 1;
        for (int i = 0; i < P && gate; i++) begin
            @(negedge clk);
            if (gate) w++;
        end
    endtask

    task automatic period_len(input string req, output int n);
        wait_rise(req);
        n = 0;
        begin
            bit p = gate;
            for (int i = 0; i < 4 * P; i++) begin
                @(negedge clk);
                n++;
                if (gate && !p) return;
                p = gate;
            end
        end
        chk(req, 0, 1);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        int w, n, hi, t0;
        // R1: reset holds gate low.
        repeat (2) @(negedge clk);
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", int'(gate), 0);
        rst_n = 1'b1;
        // R3: power-on reset not done keeps gate low.
        cur_req = "R3";
        repeat (6) @(negedge clk);
        chk("R3", int'(gate), 0);

        // R4/R5: first pulses and ramp steps.
        por_ok = 1'b1;
        cur_req = "R5";
        for (int k = 0; k <= 12; k++) begin
            pulse_width("R5", w);
            if (k == 0)  chk("R4", w, DMIN);
            if (k == 3)  chk("R5", w, DMIN);
            if (k == 4)  chk("R5", w, DMIN + 1);
            if (k == 12) chk("R5", w, DMIN + 2);
        end
        period_len("R2", n);
        chk("R2", n, P);

        // R6: ramp saturates at the upper bound.
        cur_req = "R6";
        repeat (1700) @(negedge clk);
        pulse_width("R6", w);
        chk("R6", w, DMAX);
        pulse_width("R6", w);
        chk("R6", w, DMAX);

        // R3/R7: sleep mid-pulse, then restart from the bottom.
        cur_req = "R3";
        wait_rise("R3");
        @(negedge clk);
        sleep = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3", int'(gate), 0);
        sleep = 1'b0;
        cur_req = "R7";
        pulse_width("R7", w);
        chk("R7", w, DMIN);

        // R3: overcurrent and lost power-on reset.
        cur_req = "R3";
        repeat (60) @(negedge clk);
        ocp = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3", int'(gate), 0);
        ocp = 1'b0;
        repeat (37) @(negedge clk);
        por_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3", int'(gate), 0);
        por_ok = 1'b1;
        cur_req = "R7";
        pulse_width("R7", w);
        chk("R7", w, DMIN);

        // R9: one-cycle flag one cycle into a pulse leaves 3 high cycles.
        cur_req = "R9";
        repeat (3 * P) @(negedge clk);
        wait_rise("R9");
        hi = 1;
        cmp_hi = 1'b1;
        @(negedge clk);
        if (gate) hi++;
        cmp_hi = 1'b0;
        for (int i = 2; i < P; i++) begin
            @(negedge clk);
            if (gate) hi++;
        end
        chk("R9", hi, 3);

        // R8: continuous flag suppresses all pulses.
        cur_req = "R8";
        wait_rise("R8");
        t0 = cyc;
        repeat (5) @(negedge clk);
        cmp_hi = 1'b1;
        repeat (3) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (gate) hi++;
        end
        chk("R8", hi, 0);
        repeat (7) @(negedge clk);
        cmp_hi = 1'b0;

        // R10: pulses resume on the original period grid.
        cur_req = "R10";
        wait_rise("R10");
        chk("R10", (cyc - t0) % P, 0);
        period_len("R2", n);
        chk("R2", n, P);

        repeat (5) @(negedge clk);
        cmp_en = 1'b0;
        finish_run();
    end
endmodule